// File: doc/BRIEF.md
# Data Address Translation Unit

This block turns the virtual address of a load or store into a physical address. It uses a small tagged translation buffer for ordinary pages. It also handles two bypasses: a kernel-only superpage window and an explicit physical-mode request. When a translation is refused, the block reports a fault class together with a memory-management status word. The status word tells a handler why the access failed: the direction of the access, a malformed address, a permission violation, a missing translation, or a fault-on-read / fault-on-write trap bit carried by the page entry.

The checks run in a fixed order, and the first one that fails decides the result:

- alignment;
- address validity;
- the superpage window;
- the buffer lookup;
- permissions;
- the final physical-address range check.

When the PC marks privileged code, the permission check uses an effective mode. Accesses that walk page tables report their misses as a separate class. An entry write port loads the buffer; the policy for choosing which slot to refill belongs to the caller.

Each request presented with `req_valid` produces one registered result, one cycle later, qualified by a single-cycle `out_valid`.

Top module: `dxlate_unit`

## Requirements
- R1: A request accepted at a clock edge yields its result at that same edge, with `out_valid` high for exactly one cycle per request. Synchronous reset clears `out_valid` and invalidates every buffer entry.
- R2: Size codes are 0=1, 1=2, 2=4 and 3=8 bytes. If any VA bit below the access size is set, the fault code is 1 (alignment), even in physical mode. Status bit 0 (write) is set for stores and no other status bit is set.
- R3: The permission check uses an effective mode. Mode codes are 0=kernel, 1=executive, 2=supervisor and 3=user. When `req_pc0` is 1, the effective mode is `alt_mode` if `req_alt` is set and kernel otherwise. When `req_pc0` is 0, the effective mode is `cur_mode`.
- R4: The VA is valid only if bits 63:42 are all equal. Otherwise the fault code is 2 (page) and the status has bit 5 (bad VA) and bit 1 (access violation) set, plus bit 0 for stores.
- R5: A VA with bits 47:41 equal to 0x7e bypasses the buffer. If `cur_mode` is not kernel, the fault code is 3 (violation) with status bit 1, plus bit 0 for stores. In kernel mode, the PA is the VA's low 44 bits. If PA bit 40 is set, PA bits 43:40 are forced to ones; otherwise every bit above bit 39 is cleared.
- R6: A buffer miss sets status bit 4. The fault code is 5 when `req_ptacc` is set and 4 otherwise. Status bit 0 is set for stores.
- R7: For a store that hits, a clear write-enable bit for the effective mode gives fault code 2 with status bits 0 and 1, plus bit 3 if the entry's fault-on-write bit is set. With write permission but fault-on-write set, the result is fault code 2 with status bits 0 and 3 only.
- R8: For a load that hits, a clear read-enable bit for the effective mode gives fault code 3 with status bit 1, plus bit 2 if the entry's fault-on-read bit is set. With read permission but fault-on-read set, the result is fault code 2 with only status bit 2.
- R9: Once translated, a PA with any bit at or above bit 44 set gives fault code 6 (machine check) with a zero status. A successful access returns fault code 0, a zero status, and a PA below 2^44.
- R10: A successful PA with bit 43 set raises `out_uncached` and has its bits 42:35 cleared. Any fault returns a PA of 0 with `out_uncached` low.
- R11: An entry hits when it is valid, its tag equals VA bits 42:13, and either its global bit is set or its ASN equals `cur_asn`. On a hit, the PA is the entry's page number shifted left by 13, plus VA bits 12:0. When several entries hit, the lowest index wins.
- R12: In physical mode, the PA equals the VA, and the validity, superpage, buffer and permission checks are skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Log2 of the access size in bytes |
| req_write | input | 1 | 1 = store, 0 = load |
| req_phys | input | 1 | Physical-mode access |
| req_alt | input | 1 | Use the alternate mode in privileged code |
| req_ptacc | input | 1 | Access is a page-table walk |
| req_pc0 | input | 1 | Bit 0 of the PC (privileged code marker) |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode |
| cur_asn | input | 8 | Current address-space number |
| fill_en | input | 1 | Write one buffer entry |
| fill_idx | input | 3 | Entry index to write |
| fill_vpn | input | 30 | Virtual page tag |
| fill_asn | input | 8 | Entry ASN |
| fill_global | input | 1 | Entry matches every ASN |
| fill_ppn | input | 32 | Physical page number |
| fill_rd_en | input | 4 | Read enable per mode (bit = mode code) |
| fill_wr_en | input | 4 | Write enable per mode (bit = mode code) |
| fill_fonr | input | 1 | Entry fault-on-read |
| fill_fonw | input | 1 | Entry fault-on-write |
| out_valid | output | 1 | Result strobe |
| out_pa | output | 64 | Physical address (0 on fault) |
| out_uncached | output | 1 | Uncacheable access |
| out_fault | output | 3 | Fault code |
| out_status | output | 6 | Status bits |

## Verification
The assertions take for granted that a request and an entry fill never write the same slot in the same cycle. They also assume `req_valid` is a clean level that is sampled once per cycle, so that each strobe maps to exactly one earlier request. The stimulus loads entries only while no request is pending and drives each request for a single cycle, followed by an idle cycle. It chooses addresses so that each vector trips exactly the check it targets and no earlier one in the priority order.

// File: rtl/dxlate_pkg.sv
package dxlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_ALIGN   = 3'd1,
    FLT_PAGE    = 3'd2,
    FLT_ACV     = 3'd3,
    FLT_MISS    = 3'd4,
    FLT_MISS_PT = 3'd5,
    FLT_MCHK    = 3'd6
  } fault_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_MISS  = 4;
  localparam int ST_BADVA = 5;

  localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/dxlate_tlb.sv
module dxlate_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 32,
  parameter int ASN_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic             fill_global,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [3:0]       fill_re,
  input  logic [3:0]       fill_we,
  input  logic             fill_fonr,
  input  logic             fill_fonw,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [3:0]       hit_re,
  output logic [3:0]       hit_we,
  output logic             hit_fonr,
  output logic             hit_fonw
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] glb_q;
  logic [ENTRIES-1:0] fonr_q;
  logic [ENTRIES-1:0] fonw_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [ASN_W-1:0]   asn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [3:0]         re_q  [ENTRIES];
  logic [3:0]         we_q  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel;

  // valid bits are the only reset state; entry payload is plain storage
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      glb_q[fill_idx]  <= fill_global;
      fonr_q[fill_idx] <= fill_fonr;
      fonw_q[fill_idx] <= fill_fonw;
      tag_q[fill_idx]  <= fill_vpn;
      asn_q[fill_idx]  <= fill_asn;
      ppn_q[fill_idx]  <= fill_ppn;
      re_q[fill_idx]   <= fill_re;
      we_q[fill_idx]   <= fill_we;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn) &&
                      (glb_q[g] || (asn_q[g] == lk_asn));
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign hit_ppn  = ppn_q[sel];
  assign hit_re   = re_q[sel];
  assign hit_we   = we_q[sel];
  assign hit_fonr = fonr_q[sel];
  assign hit_fonw = fonw_q[sel];
endmodule

// File: rtl/dxlate_fault.sv
module dxlate_fault
  import dxlate_pkg::*;
#(
  parameter int VA_BITS    = 43,
  parameter int PA_BITS    = 44,
  parameter int PAGE_BITS  = 13,
  parameter int PPN_W      = 32,
  parameter int SP_EXT_BIT = 40,
  parameter int UC_CLR_LO  = 35
) (
  input  logic [63:0]      va,
  input  logic [1:0]       size,
  input  logic             wr,
  input  logic             phys,
  input  logic             alt_sel,
  input  logic             ptacc,
  input  logic             pc0,
  input  logic [1:0]       cur_mode,
  input  logic [1:0]       alt_mode,
  input  logic             hit,
  input  logic [PPN_W-1:0] hit_ppn,
  input  logic [3:0]       hit_re,
  input  logic [3:0]       hit_we,
  input  logic             hit_fonr,
  input  logic             hit_fonw,
  output fault_e           fault,
  output logic [ST_W-1:0]  status,
  output logic [63:0]      pa,
  output logic             uncached
);
  localparam int UC_BIT = PA_BITS - 1;

  logic [1:0]  eff_mode;
  logic [2:0]  low_mask;
  logic        misalign;
  logic        canon;
  logic        superpg;
  logic [63:0] pa_raw;
  logic [63:0] sp_pa;
  logic [63:0] tlb_pa;
  logic        xlated;

  always_comb begin
    eff_mode = pc0 ? (alt_sel ? alt_mode : MODE_KERNEL) : cur_mode;
    case (size)
      2'd0:    low_mask = 3'b000;
      2'd1:    low_mask = 3'b001;
      2'd2:    low_mask = 3'b011;
      default: low_mask = 3'b111;
    endcase
    misalign = |(va[2:0] & low_mask);
    canon    = (&va[63:VA_BITS-1]) | ~(|va[63:VA_BITS-1]);
    superpg  = (va[47:41] == 7'h7e);

    sp_pa = va & ((64'd1 << PA_BITS) - 64'd1);
    if (sp_pa[SP_EXT_BIT]) sp_pa[PA_BITS-1:SP_EXT_BIT] = '1;
    else                   sp_pa[63:SP_EXT_BIT] = '0;

    tlb_pa = 64'({hit_ppn, va[PAGE_BITS-1:0]});
  end

  always_comb begin
    fault    = FLT_NONE;
    status   = '0;
    pa_raw   = '0;
    xlated   = 1'b0;
    pa       = '0;
    uncached = 1'b0;

    if (misalign) begin
      fault         = FLT_ALIGN;
      status[ST_WR] = wr;
    end else if (phys) begin
      pa_raw = va;
      xlated = 1'b1;
    end else if (!canon) begin
      fault            = FLT_PAGE;
      status[ST_WR]    = wr;
      status[ST_BADVA] = 1'b1;
      status[ST_ACV]   = 1'b1;
    end else if (superpg) begin
      if (cur_mode != MODE_KERNEL) begin
        fault          = FLT_ACV;
        status[ST_WR]  = wr;
        status[ST_ACV] = 1'b1;
      end else begin
        pa_raw = sp_pa;
        xlated = 1'b1;
      end
    end else if (!hit) begin
      fault           = ptacc ? FLT_MISS_PT : FLT_MISS;
      status[ST_WR]   = wr;
      status[ST_MISS] = 1'b1;
    end else if (wr) begin
      status[ST_WR] = 1'b1;
      if (!hit_we[eff_mode]) begin
        fault           = FLT_PAGE;
        status[ST_ACV]  = 1'b1;
        status[ST_FONW] = hit_fonw;
      end else if (hit_fonw) begin
        fault           = FLT_PAGE;
        status[ST_FONW] = 1'b1;
      end else begin
        status = '0;
        pa_raw = tlb_pa;
        xlated = 1'b1;
      end
    end else begin
      if (!hit_re[eff_mode]) begin
        fault           = FLT_ACV;
        status[ST_ACV]  = 1'b1;
        status[ST_FONR] = hit_fonr;
      end else if (hit_fonr) begin
        fault           = FLT_PAGE;
        status[ST_FONR] = 1'b1;
      end else begin
        pa_raw = tlb_pa;
        xlated = 1'b1;
      end
    end

    if (xlated) begin
      if (|pa_raw[63:PA_BITS]) begin
        fault = FLT_MCHK;
      end else begin
        pa = pa_raw;
        if (pa_raw[UC_BIT]) begin
          uncached = 1'b1;
          pa[UC_BIT-1:UC_CLR_LO] = '0;
        end
      end
    end
  end
endmodule

// File: rtl/dxlate_unit.sv
module dxlate_unit
  import dxlate_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int VA_BITS    = 43,
  parameter int PA_BITS    = 44,
  parameter int PAGE_BITS  = 13,
  parameter int PPN_W      = 32,
  parameter int ASN_W      = 8,
  localparam int VPN_W     = VA_BITS - PAGE_BITS,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [63:0]      req_va,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic             req_phys,
  input  logic             req_alt,
  input  logic             req_ptacc,
  input  logic             req_pc0,
  input  logic [1:0]       cur_mode,
  input  logic [1:0]       alt_mode,
  input  logic [ASN_W-1:0] cur_asn,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic             fill_global,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [3:0]       fill_rd_en,
  input  logic [3:0]       fill_wr_en,
  input  logic             fill_fonr,
  input  logic             fill_fonw,
  output logic             out_valid,
  output logic [63:0]      out_pa,
  output logic             out_uncached,
  output logic [2:0]       out_fault,
  output logic [ST_W-1:0]  out_status
);
  logic             hit;
  logic [PPN_W-1:0] hit_ppn;
  logic [3:0]       hit_re;
  logic [3:0]       hit_we;
  logic             hit_fonr;
  logic             hit_fonw;
  fault_e           c_fault;
  logic [ST_W-1:0]  c_status;
  logic [63:0]      c_pa;
  logic             c_unc;

  dxlate_tlb #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W)
  ) u_tlb (
    .clk(clk), .rst(rst),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_asn(fill_asn), .fill_global(fill_global), .fill_ppn(fill_ppn),
    .fill_re(fill_rd_en), .fill_we(fill_wr_en),
    .fill_fonr(fill_fonr), .fill_fonw(fill_fonw),
    .lk_vpn(req_va[VA_BITS-1:PAGE_BITS]), .lk_asn(cur_asn),
    .hit(hit), .hit_ppn(hit_ppn), .hit_re(hit_re), .hit_we(hit_we),
    .hit_fonr(hit_fonr), .hit_fonw(hit_fonw)
  );

  dxlate_fault #(
    .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .PAGE_BITS(PAGE_BITS),
    .PPN_W(PPN_W), .SP_EXT_BIT(40), .UC_CLR_LO(35)
  ) u_fault (
    .va(req_va), .size(req_size), .wr(req_write), .phys(req_phys),
    .alt_sel(req_alt), .ptacc(req_ptacc), .pc0(req_pc0),
    .cur_mode(cur_mode), .alt_mode(alt_mode),
    .hit(hit), .hit_ppn(hit_ppn), .hit_re(hit_re), .hit_we(hit_we),
    .hit_fonr(hit_fonr), .hit_fonw(hit_fonw),
    .fault(c_fault), .status(c_status), .pa(c_pa), .uncached(c_unc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_pa       <= '0;
      out_uncached <= 1'b0;
      out_fault    <= FLT_NONE;
      out_status   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_pa       <= c_pa;
        out_uncached <= c_unc;
        out_fault    <= c_fault;
        out_status   <= c_status;
      end
    end
  end
endmodule

// File: rtl/dxlate_sva.sv
module dxlate_sva #(
  parameter int PA_BITS = 44
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        out_valid,
  input logic [63:0] out_pa,
  input logic        out_uncached,
  input logic [2:0]  out_fault,
  input logic [5:0]  out_status
);
  assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(req_valid));

  assert_align_status_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault == 3'd1) |-> (out_status[5:1] == 5'd0));

  assert_miss_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_fault == 3'd4 || out_fault == 3'd5)) |-> out_status[4]);

  assert_clean_ok_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault == 3'd0) |->
      (out_status == 6'd0 && out_pa[63:PA_BITS] == '0));

  assert_fault_no_pa_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault != 3'd0) |-> (out_pa == 64'd0 && !out_uncached));

  assert_uc_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_uncached) |->
      (out_pa[PA_BITS-1] && out_pa[PA_BITS-2:35] == '0));
endmodule

bind dxlate_unit dxlate_sva #(.PA_BITS(PA_BITS)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .out_valid(out_valid),
  .out_pa(out_pa), .out_uncached(out_uncached), .out_fault(out_fault),
  .out_status(out_status)
);

// File: tb/dxlate_unit_tb.sv
`timescale 1ns/1ps
module dxlate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_phys, req_alt, req_ptacc, req_pc0;
  logic [63:0] req_va;
  logic [1:0]  req_size, cur_mode, alt_mode;
  logic [7:0]  cur_asn;
  logic        fill_en, fill_global, fill_fonr, fill_fonw;
  logic [2:0]  fill_idx;
  logic [29:0] fill_vpn;
  logic [7:0]  fill_asn;
  logic [31:0] fill_ppn;
  logic [3:0]  fill_rd_en, fill_wr_en;
  logic        out_valid, out_uncached;
  logic [63:0] out_pa;
  logic [2:0]  out_fault;
  logic [5:0]  out_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dxlate_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
    .req_alt(req_alt), .req_ptacc(req_ptacc), .req_pc0(req_pc0),
    .cur_mode(cur_mode), .alt_mode(alt_mode), .cur_asn(cur_asn),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
    .fill_asn(fill_asn), .fill_global(fill_global), .fill_ppn(fill_ppn),
    .fill_rd_en(fill_rd_en), .fill_wr_en(fill_wr_en),
    .fill_fonr(fill_fonr), .fill_fonw(fill_fonw),
    .out_valid(out_valid), .out_pa(out_pa), .out_uncached(out_uncached),
    .out_fault(out_fault), .out_status(out_status)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic        wr, ph, al, pt, pc;
    logic [1:0]  md, am;
    logic [7:0]  asn;
    logic [63:0] va;
    logic [2:0]  ef;
    logic [5:0]  es;
    logic [63:0] epa;
    logic        eu;
  } vec_t;

  localparam int NV = 22;
  // entries: 0 vpn 0x100 asn5 ppn 0x2000 re all we kernel; 1 vpn 0x200 global
  // re kernel we all fonr fonw; 2 vpn 0x300 ppn 0x80000000; 3 vpn 0x400 ppn 0x4FC00000
  localparam vec_t VEC [NV] = '{
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'h200008,3'd0,6'h00,64'h4000008,1'b0},   // R11 hit
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'h200004,3'd1,6'h00,64'h0,1'b0},         // R2
    '{2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'h200001,3'd1,6'h01,64'h0,1'b0},         // R2
    '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'h200010,3'd2,6'h03,64'h0,1'b0},         // R7
    '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,2'd3,2'd0,8'd5,64'h200010,3'd0,6'h00,64'h4000010,1'b0},   // R3
    '{2'd2,1'b1,1'b0,1'b1,1'b0,1'b1,2'd3,2'd3,8'd5,64'h200010,3'd2,6'h03,64'h0,1'b0},         // R3
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,8'd9,64'h400000,3'd3,6'h06,64'h0,1'b0},         // R8
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd9,64'h400000,3'd2,6'h04,64'h0,1'b0},         // R8
    '{2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd9,64'h400000,3'd2,6'h09,64'h0,1'b0},         // R7
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd6,64'h200000,3'd4,6'h10,64'h0,1'b0},         // R6 R11
    '{2'd3,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0,8'd6,64'h200000,3'd5,6'h11,64'h0,1'b0},         // R6
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd5,64'h0000100000000000,3'd2,6'h22,64'h0,1'b0}, // R4
    '{2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd5,64'h0000100000000000,3'd2,6'h23,64'h0,1'b0}, // R4
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd5,64'hFFFFFD0000000040,3'd0,6'h00,64'h80000000040,1'b1}, // R5 R10
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd5,64'hFFFFFC0000000040,3'd0,6'h00,64'h40,1'b0},  // R5
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'hFFFFFC0000000040,3'd3,6'h02,64'h0,1'b0},   // R5
    '{2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,2'd0,8'd5,64'hFFFFFC0000000040,3'd3,6'h03,64'h0,1'b0},   // R5
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd5,64'h600000,3'd6,6'h00,64'h0,1'b0},          // R9
    '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd5,64'h800010,3'd0,6'h00,64'h80000000010,1'b1},  // R10
    '{2'd3,1'b0,1'b1,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'h12345678,3'd0,6'h00,64'h12345678,1'b0}, // R12
    '{2'd3,1'b0,1'b1,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'h0004000000000000,3'd6,6'h00,64'h0,1'b0}, // R12 R9
    '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd3,2'd0,8'd5,64'h12345671,3'd1,6'h00,64'h0,1'b0}         // R2
  };

  task automatic fill(input logic [2:0] idx, input logic [29:0] vpn,
                      input logic [7:0] asn, input logic glb,
                      input logic [31:0] ppn, input logic [3:0] re,
                      input logic [3:0] we, input logic fr, input logic fw);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = idx; fill_vpn = vpn; fill_asn = asn;
    fill_global = glb; fill_ppn = ppn; fill_rd_en = re; fill_wr_en = we;
    fill_fonr = fr; fill_fonw = fw;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_size = v.sz; req_write = v.wr; req_phys = v.ph;
    req_alt = v.al; req_ptacc = v.pt; req_pc0 = v.pc; cur_mode = v.md;
    alt_mode = v.am; cur_asn = v.asn; req_va = v.va;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic check(input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_size = '0;
    req_write = 1'b0; req_phys = 1'b0; req_alt = 1'b0; req_ptacc = 1'b0;
    req_pc0 = 1'b0; cur_mode = '0; alt_mode = '0; cur_asn = '0;
    fill_en = 1'b0; fill_idx = '0; fill_vpn = '0; fill_asn = '0;
    fill_global = 1'b0; fill_ppn = '0; fill_rd_en = '0; fill_wr_en = '0;
    fill_fonr = 1'b0; fill_fonw = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", 64'(out_valid), 64'd0);
    @(negedge clk) rst = 1'b0;

    fill(3'd0, 30'h100, 8'd5, 1'b0, 32'h2000,     4'b1111, 4'b0001, 1'b0, 1'b0);
    fill(3'd1, 30'h200, 8'd0, 1'b1, 32'h3,        4'b0001, 4'b1111, 1'b1, 1'b1);
    fill(3'd2, 30'h300, 8'd5, 1'b0, 32'h80000000, 4'b1111, 4'b1111, 1'b0, 1'b0);
    fill(3'd3, 30'h400, 8'd5, 1'b0, 32'h4FC00000, 4'b1111, 4'b1111, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("R1 valid v%0d", i), 64'(out_valid), 64'd1);
      check($sformatf("fault v%0d", i), 64'(out_fault), 64'(VEC[i].ef));
      check($sformatf("status v%0d", i), 64'(out_status), 64'(VEC[i].es));
      check($sformatf("pa v%0d", i), out_pa, VEC[i].epa);
      check($sformatf("uncached v%0d", i), 64'(out_uncached), 64'(VEC[i].eu));
    end

    // R1: strobe lasts one cycle
    @(posedge clk); #1;
    check("R1 strobe drop", 64'(out_valid), 64'd0);

    // R11: duplicate match, lowest index wins (entry 4 and 5 same tag)
    fill(3'd5, 30'h500, 8'd5, 1'b0, 32'h7, 4'b1111, 4'b1111, 1'b0, 1'b0);
    fill(3'd4, 30'h500, 8'd5, 1'b0, 32'h6, 4'b1111, 4'b1111, 1'b0, 1'b0);
    apply('{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,8'd5,64'hA00003,3'd0,6'h00,64'h0,1'b0});
    check("R11 lowest index", out_pa, 64'hC003);

    // R1: reset invalidates entries
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    apply(VEC[0]);
    check("R1 entries cleared", 64'(out_fault), 64'd4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule